// File: doc/BRIEF.md
# FM Operator Envelope Generator

This block keeps the envelope phase and the attenuation of a single FM synthesis operator and advances them each time a shared envelope counter steps. The counter itself is produced elsewhere. In the intended system it steps once every three output samples. The block receives the counter value together with a one-cycle strobe that marks each step. It also receives key-on and key-off pulses, one rate word for each active phase, a sustain threshold and a total level. It drives the summed attenuation that a later log-sine stage would use.

Each rate word combines a gating shift with eight small increment codes. The gating shift thins out how often the envelope is updated. The counter bits above the shift choose which increment code applies to a given update. The attack phase adds a negative term proportional to the complement of the present attenuation, so attenuation falls along an exponential curve. Decay, sustain and release add the chosen increment directly.

Top module: `fm_env_slot`

## Requirements
- R1: After reset the phase is off (code 0) and the attenuation is 1023, so the output reads total_level*8 + 1023.
- R2: The phase output uses off = 0, release = 1, sustain = 2, decay = 3 and attack = 4. A key-on pulse moves the phase to attack on the next clock edge and leaves the attenuation unchanged. A key-off pulse moves any phase other than off to release, and is ignored when the phase is off. When both pulses arrive together, key-on wins.
- R3: An update happens only on a clock edge where the strobe is high, the phase is not off, and the low S bits of the counter are all zero. S is bits [31:24] of the rate word of the current phase. If S is not smaller than the counter width, the whole counter must be zero. In every other case the phase and the attenuation stay as they are.
- R4: The code index is (counter >> S) & 7. Code k is the 3-bit field at bits [3k+2:3k] of the rate word. The increment is (1 << code) >> 1, which gives 0, 1, 2, 4, 8, 16, 32 or 64.
- R5: In attack, the new attenuation is a + ((-(a+1)*inc) >>> 4), using signed arithmetic. If the result is zero or negative, the attenuation becomes 0 and the phase becomes decay. This also happens when a is already 0 and the increment is 0.
- R6: In decay, the increment is added, with the result limited to 1023. Once the result is equal to or greater than the sustain level, the phase becomes sustain.
- R7: In sustain, the increment is added and the result saturates at 1023. The phase stays sustain.
- R8: In release, the increment is added. When the result reaches or passes 1023, the attenuation becomes 1023 and the phase becomes off.
- R9: While the phase is off, strobes leave both the phase and the attenuation unchanged.
- R10: The output is total_level*8 + attenuation, at all times. Its range is 0 to 2039.
- R11: Each phase reads only its own rate word. Attack uses the attack word, decay the decay word, sustain the sustain word and release the release word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| env_tick | input | 1 | One-cycle strobe: the envelope counter has stepped |
| env_cnt | input | 12 | Current envelope counter value |
| key_on | input | 1 | Start-of-note pulse |
| key_off | input | 1 | End-of-note pulse |
| rate_atk | input | 32 | Attack rate word: shift in [31:24], codes in [23:0] |
| rate_dec | input | 32 | Decay rate word |
| rate_sus | input | 32 | Sustain rate word |
| rate_rel | input | 32 | Release rate word |
| sus_lvl | input | 10 | Attenuation at which decay hands over to sustain |
| tot_lvl | input | 7 | Total level, weighted by 8 in the output |
| env_phase | output | 3 | Current phase code |
| att_out | output | 11 | Total level*8 plus attenuation |

## Verification
The update path is driven with rate words whose codes all match, which separates the exponential attack from the linear phases by the shape of the curve that results. A word whose codes are all different is then swept through every index. This shows which 3-bit field is chosen and confirms that code 0 adds nothing. Counter values with and without low bits set, strobe-free cycles and an oversized shift separate gated updates from skipped ones. Colliding key pulses, a key-off while off, and a zero attack word next to a busy decay word show that events take priority and that each phase reads only its own rate word.

// File: rtl/fm_env_pkg.sv
package fm_env_pkg;
   typedef enum logic [2:0] {
      PH_OFF = 3'd0,
      PH_REL = 3'd1,
      PH_SUS = 3'd2,
      PH_DEC = 3'd3,
      PH_ATK = 3'd4
   } env_phase_e;
endpackage

// File: rtl/fm_env_gate.sv
module fm_env_gate #(
   parameter int CNT_W   = 12,
   parameter int SHAMT_W = 8,
   parameter int CODE_W  = 3,
   parameter int IDX_W   = 3,
   localparam int N_CODES = 1 << IDX_W,
   localparam int RATE_W  = SHAMT_W + N_CODES * CODE_W,
   localparam int INC_W   = (1 << CODE_W) - 1
) (
   input  logic [RATE_W-1:0] rate_word,
   input  logic [CNT_W-1:0]  cnt,
   output logic              fire,
   output logic [INC_W-1:0]  inc
);
   logic [SHAMT_W-1:0]        shamt;
   logic [CNT_W-1:0]          low_mask;
   logic [CNT_W-1:0]          shifted;
   logic [IDX_W-1:0]          idx;
   logic [CODE_W-1:0]         code;
   logic [CODE_W-1:0]         codes [N_CODES];

   assign shamt = rate_word[RATE_W-1 -: SHAMT_W];

   for (genvar g = 0; g < N_CODES; g++) begin : g_code
      assign codes[g] = rate_word[g*CODE_W +: CODE_W];
   end

   always_comb begin
      for (int k = 0; k < CNT_W; k++) begin
         low_mask[k] = (SHAMT_W'(k) < shamt);
      end
   end

   assign fire    = ((cnt & low_mask) == '0);
   assign shifted = cnt >> shamt;
   assign idx     = shifted[IDX_W-1:0];
   assign code    = codes[idx];

   always_comb begin
      if (code == '0) inc = '0;
      else            inc = INC_W'(1) << (code - CODE_W'(1));
   end

   if (CNT_W < IDX_W) begin : g_bad_cnt
      $error("fm_env_gate: counter narrower than code index");
   end
endmodule

// File: rtl/fm_env_step.sv
module fm_env_step
   import fm_env_pkg::*;
#(
   parameter int ATT_W  = 10,
   parameter int INC_W  = 7,
   localparam int MUL_W = ATT_W + INC_W + 3,
   localparam int SUM_W = ATT_W + 2
) (
   input  env_phase_e        phase,
   input  logic [ATT_W-1:0]  att,
   input  logic [INC_W-1:0]  inc,
   input  logic [ATT_W-1:0]  sus_lvl,
   output env_phase_e        nphase,
   output logic [ATT_W-1:0]  natt
);
   localparam logic [SUM_W-1:0] MAX_S = SUM_W'((1 << ATT_W) - 1);

   logic signed [MUL_W-1:0] cpl;
   logic signed [MUL_W-1:0] inc_s;
   logic signed [MUL_W-1:0] prod;
   logic signed [MUL_W-1:0] atk_sum;
   logic        [SUM_W-1:0] lin_sum;
   logic        [SUM_W-1:0] lin_sat;

   assign cpl     = -($signed({{(MUL_W-ATT_W){1'b0}}, att}) + MUL_W'(1));
   assign inc_s   = $signed({{(MUL_W-INC_W){1'b0}}, inc});
   assign prod    = cpl * inc_s;
   assign atk_sum = $signed({{(MUL_W-ATT_W){1'b0}}, att}) + (prod >>> 4);

   assign lin_sum = SUM_W'(att) + SUM_W'(inc);
   assign lin_sat = (lin_sum >= MAX_S) ? MAX_S : lin_sum;

   always_comb begin
      nphase = phase;
      natt   = att;
      unique case (phase)
         PH_ATK: begin
            if (atk_sum <= 0) begin
               natt   = '0;
               nphase = PH_DEC;
            end else begin
               natt = atk_sum[ATT_W-1:0];
            end
         end
         PH_DEC: begin
            natt = lin_sat[ATT_W-1:0];
            if (lin_sum >= SUM_W'(sus_lvl)) nphase = PH_SUS;
         end
         PH_SUS: begin
            natt = lin_sat[ATT_W-1:0];
         end
         PH_REL: begin
            natt = lin_sat[ATT_W-1:0];
            if (lin_sum >= MAX_S) nphase = PH_OFF;
         end
         default: ;
      endcase
   end

   if (INC_W >= ATT_W) begin : g_bad_inc
      $error("fm_env_step: increment as wide as attenuation");
   end
endmodule

// File: rtl/fm_env_slot.sv
module fm_env_slot
   import fm_env_pkg::*;
#(
   parameter int CNT_W   = 12,
   parameter int ATT_W   = 10,
   parameter int TL_W    = 7,
   parameter int TL_SH   = 3,
   parameter int SHAMT_W = 8,
   parameter int CODE_W  = 3,
   parameter int IDX_W   = 3,
   localparam int RATE_W = SHAMT_W + (1 << IDX_W) * CODE_W,
   localparam int INC_W  = (1 << CODE_W) - 1,
   localparam int OUT_W  = ATT_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              env_tick,
   input  logic [CNT_W-1:0]  env_cnt,
   input  logic              key_on,
   input  logic              key_off,
   input  logic [RATE_W-1:0] rate_atk,
   input  logic [RATE_W-1:0] rate_dec,
   input  logic [RATE_W-1:0] rate_sus,
   input  logic [RATE_W-1:0] rate_rel,
   input  logic [ATT_W-1:0]  sus_lvl,
   input  logic [TL_W-1:0]   tot_lvl,
   output logic [2:0]        env_phase,
   output logic [OUT_W-1:0]  att_out
);
   localparam logic [ATT_W-1:0] ATT_MAX = '1;

   env_phase_e        phase_q, nphase;
   logic [ATT_W-1:0]  att_q, natt;
   logic [RATE_W-1:0] rate_sel;
   logic              fire;
   logic [INC_W-1:0]  inc;

   always_comb begin
      unique case (phase_q)
         PH_ATK:  rate_sel = rate_atk;
         PH_DEC:  rate_sel = rate_dec;
         PH_SUS:  rate_sel = rate_sus;
         default: rate_sel = rate_rel;
      endcase
   end

   fm_env_gate #(
      .CNT_W(CNT_W), .SHAMT_W(SHAMT_W), .CODE_W(CODE_W), .IDX_W(IDX_W)
   ) u_gate (
      .rate_word(rate_sel),
      .cnt      (env_cnt),
      .fire     (fire),
      .inc      (inc)
   );

   fm_env_step #(
      .ATT_W(ATT_W), .INC_W(INC_W)
   ) u_step (
      .phase  (phase_q),
      .att    (att_q),
      .inc    (inc),
      .sus_lvl(sus_lvl),
      .nphase (nphase),
      .natt   (natt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_OFF;
         att_q   <= ATT_MAX;
      end else if (key_on) begin
         phase_q <= PH_ATK;
      end else if (key_off) begin
         if (phase_q != PH_OFF) phase_q <= PH_REL;
      end else if (env_tick && fire && phase_q != PH_OFF) begin
         phase_q <= nphase;
         att_q   <= natt;
      end
   end

   assign env_phase = phase_q;
   assign att_out   = OUT_W'({tot_lvl, {TL_SH{1'b0}}}) + OUT_W'(att_q);

   if (TL_W + TL_SH > ATT_W) begin : g_bad_tl
      $error("fm_env_slot: total level overflows output");
   end

   p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!env_tick && !key_on && !key_off) |=> ($stable(att_q) && $stable(phase_q)));

   p_keyon_r2: assert property (@(posedge clk) disable iff (!rst_n)
      key_on |=> (phase_q == PH_ATK));

   p_keyoff_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (key_off && !key_on && phase_q != PH_OFF) |=> (phase_q == PH_REL));

   p_off_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_OFF && !key_on) |=> (phase_q == PH_OFF && $stable(att_q)));

   p_atk_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_ATK && !key_on && !key_off) |=> (phase_q == PH_ATK || att_q == '0));

   p_sus_stay_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_SUS && !key_on && !key_off) |=> (phase_q == PH_SUS && att_q >= $past(att_q)));

   p_rel_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_REL && !key_on && !key_off) |=>
         (phase_q == PH_REL || (phase_q == PH_OFF && att_q == ATT_MAX)));
endmodule

// File: tb/sim_fm_env_slot.sv
module sim_fm_env_slot;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        env_tick = 1'b0;
   logic [11:0] env_cnt = '0;
   logic        key_on = 1'b0, key_off = 1'b0;
   logic [31:0] rate_atk = '0, rate_dec = '0, rate_sus = '0, rate_rel = '0;
   logic [9:0]  sus_lvl = 10'd600;
   logic [6:0]  tot_lvl = 7'd5;
   logic [2:0]  env_phase;
   logic [10:0] att_out;

   int checks = 0, errors = 0;
   int m_st = 0, m_att = 1023;

   always #4 clk = ~clk;

   fm_env_slot u0 (
      .clk(clk), .rst_n(rst_n), .env_tick(env_tick), .env_cnt(env_cnt),
      .key_on(key_on), .key_off(key_off),
      .rate_atk(rate_atk), .rate_dec(rate_dec), .rate_sus(rate_sus), .rate_rel(rate_rel),
      .sus_lvl(sus_lvl), .tot_lvl(tot_lvl), .env_phase(env_phase), .att_out(att_out)
   );

   function automatic logic [31:0] uni(int sh, int code);
      logic [31:0] w = 32'(sh) << 24;
      for (int i = 0; i < 8; i++) w |= 32'(code) << (3*i);
      return w;
   endfunction

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic model(bit tk, int cnt, bit kon, bit koff);
      logic [31:0] w;
      int sh, idx, code, inc, s;
      bit fires;
      if (kon) m_st = 4;
      else if (koff) begin if (m_st != 0) m_st = 1; end
      else if (tk && m_st != 0) begin
         w = (m_st == 4) ? rate_atk : (m_st == 3) ? rate_dec : (m_st == 2) ? rate_sus : rate_rel;
         sh = int'(w[31:24]);
         fires = (sh >= 12) ? (cnt == 0) : ((cnt & ((1 << sh) - 1)) == 0);
         if (fires) begin
            idx  = (sh >= 12) ? 0 : ((cnt >> sh) & 7);
            code = int'((w >> (3*idx)) & 32'd7);
            inc  = (1 << code) >> 1;
            case (m_st)
               4: begin
                  s = m_att + ((-(m_att + 1) * inc) >>> 4);
                  if (s <= 0) begin m_att = 0; m_st = 3; end else m_att = s;
               end
               3: begin
                  s = m_att + inc;
                  m_att = (s > 1023) ? 1023 : s;
                  if (s >= int'(sus_lvl)) m_st = 2;
               end
               2: begin s = m_att + inc; m_att = (s > 1023) ? 1023 : s; end
               default: begin
                  s = m_att + inc;
                  if (s >= 1023) begin m_att = 1023; m_st = 0; end else m_att = s;
               end
            endcase
         end
      end
   endtask

   task automatic cyc(bit tk, int cnt, bit kon, bit koff, string tag);
      @(negedge clk);
      env_tick = tk; env_cnt = 12'(cnt); key_on = kon; key_off = koff;
      @(posedge clk);
      model(tk, cnt, kon, koff);
      @(negedge clk);
      env_tick = 1'b0; key_on = 1'b0; key_off = 1'b0;
      chk({tag, " phase"}, int'(env_phase), m_st);
      chk({tag, " out"}, int'(att_out), int'(tot_lvl) * 8 + m_att);
   endtask

   task automatic t_reset_r1;
      chk("R1 reset phase", int'(env_phase), 0);
      chk("R1 reset out", int'(att_out), 5 * 8 + 1023);
   endtask

   task automatic t_off_hold_r9;
      rate_rel = uni(0, 7);
      for (int i = 0; i < 4; i++) cyc(1, i * 3, 0, 0, "R9 off hold");
      cyc(0, 0, 0, 1, "R2 key-off while off ignored");
   endtask

   task automatic t_attack_r5;
      rate_atk = uni(0, 4);
      cyc(0, 0, 1, 0, "R2 key-on to attack");
      for (int i = 0; i < 20 && m_st == 4; i++) cyc(1, i, 0, 0, "R5 attack curve");
      chk("R5 attack ends in decay", int'(env_phase), 3);
      chk("R5 attack ends at zero", int'(att_out), int'(tot_lvl) * 8);
   endtask

   task automatic t_gate_r3;
      rate_dec = uni(2, 3);
      cyc(1, 5, 0, 0, "R3 low bits set");
      cyc(0, 0, 0, 0, "R3 no strobe");
      cyc(1, 8, 0, 0, "R3 gated update");
      rate_dec = uni(20, 3);
      cyc(1, 4, 0, 0, "R3 big shift nonzero count");
      cyc(1, 0, 0, 0, "R3 big shift zero count");
   endtask

   task automatic t_codes_r4;
      logic [31:0] w = 32'(1) << 24;
      for (int i = 0; i < 8; i++) w |= 32'(i) << (3*i);
      rate_dec = w;
      for (int i = 0; i < 8; i++) cyc(1, i << 1, 0, 0, "R4 code sweep");
   endtask

   task automatic t_decay_r6;
      rate_dec = uni(0, 7);
      for (int i = 0; i < 20 && m_st == 3; i++) cyc(1, i, 0, 0, "R6 decay climb");
      chk("R6 reached sustain", int'(env_phase), 2);
   endtask

   task automatic t_sustain_r7;
      rate_sus = uni(0, 7);
      tot_lvl = 7'd127;
      for (int i = 0; i < 12; i++) cyc(1, i, 0, 0, "R7 sustain saturate");
      chk("R7 stays sustain", int'(env_phase), 2);
      chk("R10 maximum output", int'(att_out), 2039);
   endtask

   task automatic t_release_r8;
      tot_lvl = 7'd0;
      rate_atk = uni(0, 7);
      cyc(0, 0, 1, 1, "R2 key-on beats key-off");
      for (int i = 0; i < 20 && m_st == 4; i++) cyc(1, i, 0, 0, "R5 fast attack");
      rate_dec = uni(0, 2);
      cyc(1, 0, 0, 0, "R6 small decay step");
      cyc(0, 0, 0, 1, "R2 key-off to release");
      rate_rel = uni(0, 6);
      for (int i = 0; i < 40 && m_st == 1; i++) cyc(1, i, 0, 0, "R8 release climb");
      chk("R8 release ends off", int'(env_phase), 0);
      chk("R10 zero total level", int'(att_out), 1023);
   endtask

   task automatic t_own_word_r11;
      tot_lvl = 7'd9;
      rate_atk = uni(0, 0);
      rate_dec = uni(0, 7);
      cyc(0, 0, 1, 0, "R11 key-on");
      for (int i = 0; i < 3; i++) cyc(1, i, 0, 0, "R11 attack uses own word");
      chk("R11 still attack", int'(env_phase), 4);
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      t_reset_r1();
      t_off_hold_r9();
      t_attack_r5();
      t_gate_r3();
      t_codes_r4();
      t_decay_r6();
      t_sustain_r7();
      t_release_r8();
      t_own_word_r11();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule